// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block is the front end of a small accumulator CPU controller. It reads an opcode byte from byte-wide memory and finds the instruction length from the opcode. It then gathers any operand bytes that follow. A single data byte goes to an immediate holding register. A two-byte absolute address is built in a split address register, low byte first. When everything for one instruction has been gathered, the block raises a one-cycle ready pulse. The opcode, the length, the immediate byte and the address are all valid together during that pulse.

The program counter drives the memory address bus directly. Each byte read takes two cycles: one to issue the address and one to capture the data. The counter steps once per byte, in the capture cycle. After the ready pulse the sequencer goes straight on to the next opcode fetch. An execution unit outside this block can redirect that fetch with a PC-load strobe and a 16-bit target.

Top module: `insn_fetch_seq`

## Requirements
- R1: While rst_ni is low, pc_o, ir_o, imm_o, ar_o and len_o are zero, and ready_o and mem_rd_o are low.
- R2: Each byte read shows mem_rd_o high for exactly one cycle, with mem_addr_o equal to pc_o. Memory returns the data on mem_rdata_i in the next cycle. The first read after reset is at 0x0000, and the reads of one instruction use consecutive addresses.
- R3: The length comes from opcode bits [7:6]: 00 gives one byte, 01 gives two bytes (opcode and immediate), 10 gives three bytes (opcode, address low, address high), and 11 is treated as one byte.
- R4: A one-byte instruction leaves imm_o and ar_o unchanged.
- R5: A two-byte instruction puts its second byte on imm_o and leaves ar_o unchanged.
- R6: A three-byte instruction sets ar_o to {third byte, second byte} and leaves imm_o unchanged.
- R7: The program counter advances by the instruction length, modulo 2^16. At the ready pulse, pc_o equals the opcode address plus the length. The counter does not move in an address-issue cycle.
- R8: ready_o is high for exactly one cycle. Consecutive pulses are 2*len+1 cycles apart, and the first pulse after reset comes 2*len+1 cycles after the release of reset.
- R9: pc_load_i loads pc_target_i into the program counter in any cycle and takes priority over the increment. A load made during the ready pulse makes the next opcode fetch come from the target.
- R10: During the ready pulse, ir_o holds the opcode and len_o holds its length as 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 16 | Memory byte address (the program counter) |
| mem_rd_o | output | 1 | Read strobe, address-issue cycle |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the strobe |
| pc_load_i | input | 1 | Load program counter from target |
| pc_target_i | input | 16 | Program counter load value |
| pc_o | output | 16 | Current program counter |
| ir_o | output | 8 | Instruction register |
| imm_o | output | 8 | Immediate data register |
| ar_o | output | 16 | Assembled absolute address |
| len_o | output | 2 | Length of the ready instruction |
| ready_o | output | 1 | One-cycle instruction-ready pulse |

## Verification
The bench memory computes each byte from its address, so a long sequential run meets a varied mix of one-, two- and three-byte opcodes back to back. That run separates length decoding, operand steering and PC stepping. A second pass redirects every fetch to address {k,0x00}, where the memory returns k as the opcode, so all 256 opcodes are decoded. That pass also confirms that a load in the ready cycle overrides the increment. A final run starting at 0xFFFE makes operand reads cross the top of memory, which tells apart a counter that wraps modulo 2^16 from one that does not.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam int LEN_W = 2;

  typedef enum logic [2:0] {
    S_INIT, S_OP_A, S_OP_C, S_B1_A, S_B1_C, S_B2_A, S_B2_C, S_RDY
  } state_e;

  // opcode class (top two bits) -> length in bytes; unknown class is one byte
  function automatic logic [LEN_W-1:0] insn_len(input logic [1:0] cls);
    case (cls)
      2'b01:   return LEN_W'(2);
      2'b10:   return LEN_W'(3);
      default: return LEN_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/ifs_split_reg.sv
module ifs_split_reg #(
  parameter int HALF_W = 8,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_full_i,
  input  logic [FULL_W-1:0] full_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [HALF_W-1:0] byte_i,
  input  logic              inc_i,
  output logic [FULL_W-1:0] q_o
);
  logic [HALF_W-1:0] lo_q, hi_q, lo_d, hi_d;

  always_comb begin
    {hi_d, lo_d} = {hi_q, lo_q};
    if (ld_full_i) begin
      {hi_d, lo_d} = full_i;
    end else begin
      if (inc_i)   {hi_d, lo_d} = {hi_q, lo_q} + FULL_W'(1);
      if (ld_lo_i) lo_d = byte_i;
      if (ld_hi_i) hi_d = byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign q_o = {hi_q, lo_q};
endmodule

// File: rtl/ifs_ctrl.sv
module ifs_ctrl
  import ifs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       op_cls_i,
  output logic             mem_rd_o,
  output logic             ir_ld_o,
  output logic             imm_ld_o,
  output logic             ar_lo_ld_o,
  output logic             ar_hi_ld_o,
  output logic             pc_inc_o,
  output logic             ready_o,
  output logic [LEN_W-1:0] len_o
);
  state_e st_q, st_d;
  logic [LEN_W-1:0] len_q, len_d;

  always_comb begin
    st_d       = st_q;
    len_d      = len_q;
    mem_rd_o   = 1'b0;
    ir_ld_o    = 1'b0;
    imm_ld_o   = 1'b0;
    ar_lo_ld_o = 1'b0;
    ar_hi_ld_o = 1'b0;
    pc_inc_o   = 1'b0;
    ready_o    = 1'b0;
    unique case (st_q)
      S_INIT: st_d = S_OP_A;
      S_OP_A: begin
        mem_rd_o = 1'b1;
        st_d     = S_OP_C;
      end
      S_OP_C: begin
        ir_ld_o  = 1'b1;
        pc_inc_o = 1'b1;
        len_d    = insn_len(op_cls_i);
        st_d     = (insn_len(op_cls_i) == LEN_W'(1)) ? S_RDY : S_B1_A;
      end
      S_B1_A: begin
        mem_rd_o = 1'b1;
        st_d     = S_B1_C;
      end
      S_B1_C: begin
        pc_inc_o = 1'b1;
        if (len_q == LEN_W'(2)) begin
          imm_ld_o = 1'b1;
          st_d     = S_RDY;
        end else begin
          ar_lo_ld_o = 1'b1;
          st_d       = S_B2_A;
        end
      end
      S_B2_A: begin
        mem_rd_o = 1'b1;
        st_d     = S_B2_C;
      end
      S_B2_C: begin
        pc_inc_o   = 1'b1;
        ar_hi_ld_o = 1'b1;
        st_d       = S_RDY;
      end
      S_RDY: begin
        ready_o = 1'b1;
        st_d    = S_OP_A;
      end
      default: st_d = S_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_INIT;
      len_q <= '0;
    end else begin
      st_q  <= st_d;
      len_q <= len_d;
    end
  end

  assign len_o = len_q;
endmodule

// File: rtl/insn_fetch_seq.sv
module insn_fetch_seq
  import ifs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              pc_load_i,
  input  logic [ADDR_W-1:0] pc_target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] imm_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              ready_o
);
  logic ir_ld, imm_ld, ar_lo_ld, ar_hi_ld, pc_inc;
  logic [DATA_W-1:0] ir_q, imm_q;

  ifs_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_cls_i   (mem_rdata_i[DATA_W-1 -: 2]),
    .mem_rd_o   (mem_rd_o),
    .ir_ld_o    (ir_ld),
    .imm_ld_o   (imm_ld),
    .ar_lo_ld_o (ar_lo_ld),
    .ar_hi_ld_o (ar_hi_ld),
    .pc_inc_o   (pc_inc),
    .ready_o    (ready_o),
    .len_o      (len_o)
  );

  ifs_split_reg #(.HALF_W(DATA_W)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_full_i (pc_load_i),
    .full_i    (pc_target_i),
    .ld_lo_i   (1'b0),
    .ld_hi_i   (1'b0),
    .byte_i    ('0),
    .inc_i     (pc_inc),
    .q_o       (pc_o)
  );

  ifs_split_reg #(.HALF_W(DATA_W)) u_ar (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_full_i (1'b0),
    .full_i    ('0),
    .ld_lo_i   (ar_lo_ld),
    .ld_hi_i   (ar_hi_ld),
    .byte_i    (mem_rdata_i),
    .inc_i     (1'b0),
    .q_o       (ar_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q  <= '0;
      imm_q <= '0;
    end else begin
      if (ir_ld)  ir_q  <= mem_rdata_i;
      if (imm_ld) imm_q <= mem_rdata_i;
    end
  end

  assign mem_addr_o = pc_o;
  assign ir_o       = ir_q;
  assign imm_o      = imm_q;
endmodule

// File: rtl/insn_fetch_seq_chk.sv
module insn_fetch_seq_chk
  import ifs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              pc_load_i,
  input logic [ADDR_W-1:0] pc_target_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [DATA_W-1:0] ir_o,
  input logic [DATA_W-1:0] imm_o,
  input logic [ADDR_W-1:0] ar_o,
  input logic [LEN_W-1:0]  len_o,
  input logic              ready_o
);
  a_r8_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  a_r2_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  a_r7_hold_in_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !pc_load_i) |=> (pc_o == $past(mem_addr_o)));

  a_r7_step_in_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mem_rd_o) && !pc_load_i) |=> (pc_o == $past(pc_o) + ADDR_W'(1)));

  a_r9_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_i |=> (pc_o == $past(pc_target_i)));

  a_r4_imm_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && len_o != LEN_W'(2)) |-> $stable(imm_o));

  a_r6_ar_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && len_o != LEN_W'(3)) |-> $stable(ar_o));

  a_r10_len_matches_ir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (len_o == insn_len(ir_o[DATA_W-1 -: 2])));

  a_r2_rd_not_at_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_rd_o);
endmodule

bind insn_fetch_seq insn_fetch_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/insn_fetch_seq_bench.sv
module insn_fetch_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = '0;
  logic        pc_load = 1'b0;
  logic [15:0] pc_target = '0;
  logic [15:0] pc;
  logic [7:0]  ir, imm;
  logic [15:0] ar;
  logic [1:0]  len;
  logic        ready;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_pc = '0;
  logic [7:0]  exp_imm = '0;
  logic [15:0] exp_ar = '0;

  always #2 clk = ~clk;

  insn_fetch_seq u_insn_fetch_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
    .pc_load_i(pc_load), .pc_target_i(pc_target),
    .pc_o(pc), .ir_o(ir), .imm_o(imm), .ar_o(ar), .len_o(len), .ready_o(ready)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    logic [7:0] lo, hi;
    lo = a[7:0];
    hi = a[15:8];
    if (lo == 8'h00) return hi;
    return lo * 8'd13 + hi * 8'd7 + 8'h5B;
  endfunction

  function automatic int len_of(input logic [7:0] op);
    case (op[7:6])
      2'b01:   return 2;
      2'b10:   return 3;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic run_insn(input bit do_load, input logic [15:0] tgt);
    int cyc = 0;
    int nrd = 0;
    logic [15:0] start = exp_pc;
    logic [7:0] op = memf(start);
    int l = len_of(op);
    forever begin
      @(negedge clk);
      pc_load = 1'b0;
      cyc++;
      if (mem_rd) begin
        chk(mem_addr == start + 16'(nrd), "R2 read address", mem_addr, start + 16'(nrd));
        nrd++;
      end
      if (ready || cyc > 40) break;
    end
    chk(ready, "R8 ready reached", ready, 1);
    chk(cyc == 2 * l + 1, "R8 ready spacing", cyc, 2 * l + 1);
    chk(nrd == l, "R2 read count", nrd, l);
    chk(ir == op, "R10 opcode", ir, op);
    chk(len == 2'(l), "R3 length class", len, l);
    if (l == 2) exp_imm = memf(start + 16'd1);
    if (l == 3) exp_ar = {memf(start + 16'd2), memf(start + 16'd1)};
    chk(imm == exp_imm, l == 2 ? "R5 immediate" : "R4 R6 immediate kept", imm, exp_imm);
    chk(ar == exp_ar, l == 3 ? "R6 address low first" : "R4 R5 address kept", ar, exp_ar);
    chk(pc == start + 16'(l), "R7 pc advance", pc, start + 16'(l));
    if (do_load) begin
      pc_load = 1'b1;
      pc_target = tgt;
      exp_pc = tgt;  // R9 next fetch from target
    end else begin
      exp_pc = start + 16'(l);
    end
    @(negedge clk);
    pc_load = 1'b0;
    chk(!ready, "R8 ready one cycle", ready, 0);
    chk(pc == exp_pc, "R9 pc after ready", pc, exp_pc);
    chk(mem_rd && mem_addr == exp_pc, "R9 next fetch address", mem_addr, exp_pc);
    // re-align: the task loop counts from the cycle after ready
    exp_pc = exp_pc;
  endtask

  // variant used after the first call: first negedge of the next insn already consumed
  task automatic run_next(input bit do_load, input logic [15:0] tgt);
    int cyc = 1;
    int nrd = 1;
    logic [15:0] start = exp_pc;
    logic [7:0] op = memf(start);
    int l = len_of(op);
    forever begin
      @(negedge clk);
      cyc++;
      if (mem_rd) begin
        chk(mem_addr == start + 16'(nrd), "R2 read address", mem_addr, start + 16'(nrd));
        nrd++;
      end
      if (ready || cyc > 40) break;
    end
    chk(ready, "R8 ready reached", ready, 1);
    chk(cyc == 2 * l + 1, "R8 ready spacing", cyc, 2 * l + 1);
    chk(nrd == l, "R2 read count", nrd, l);
    chk(ir == op, "R10 opcode", ir, op);
    chk(len == 2'(l), "R3 length class", len, l);
    if (l == 2) exp_imm = memf(start + 16'd1);
    if (l == 3) exp_ar = {memf(start + 16'd2), memf(start + 16'd1)};
    chk(imm == exp_imm, l == 2 ? "R5 immediate" : "R4 R6 immediate kept", imm, exp_imm);
    chk(ar == exp_ar, l == 3 ? "R6 address low first" : "R4 R5 address kept", ar, exp_ar);
    chk(pc == start + 16'(l), "R7 pc advance", pc, start + 16'(l));
    if (do_load) begin
      pc_load = 1'b1;
      pc_target = tgt;
      exp_pc = tgt;
    end else begin
      exp_pc = start + 16'(l);
    end
    @(negedge clk);
    pc_load = 1'b0;
    chk(!ready, "R8 ready one cycle", ready, 0);
    chk(pc == exp_pc, "R9 pc after ready", pc, exp_pc);
    chk(mem_rd && mem_addr == exp_pc, "R9 next fetch address", mem_addr, exp_pc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pc == 16'h0, "R1 pc reset", pc, 0);
    chk(ir == 8'h0 && imm == 8'h0, "R1 ir imm reset", {ir, imm}, 0);
    chk(ar == 16'h0 && len == 2'd0, "R1 ar len reset", {ar, 14'h0, len}, 0);
    chk(!ready && !mem_rd, "R1 no ready no read", {ready, mem_rd}, 0);
    rst_n = 1'b1;
    run_insn(1'b0, 16'h0);
    for (int i = 0; i < 299; i++) run_next(i == 298, 16'h0000);
    // opcode sweep: memory at {k,00} holds k
    for (int k = 0; k < 256; k++)
      run_next(1'b1, (k == 255) ? 16'hFFFE : {8'(k + 1), 8'h00});
    // wrap across 0xFFFF
    for (int i = 0; i < 8; i++) run_next(1'b0, 16'h0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule